// File: doc/BRIEF.md
# PCM Sample FIFO with DMA Request Control

This block holds the two sample queues that sit between a processor bus and a PCM serializer. A write to the data register enqueues a transmit sample. A read of the same register dequeues a receive sample. The serializer takes transmit samples through a pop strobe and delivers receive samples through a push strobe. Each queue is 64 words deep by default.

The block drives a request line and a more urgent panic line toward a DMA engine for each direction. The thresholds for these four lines sit in one level register. It reports the fill state and two sticky overflow errors, and it raises one interrupt line from a maskable set of four conditions.

Three control operations are timed in PCM bit-clock periods, signalled by a one-cycle `bclk_tick` strobe in the system clock domain:
- A queue flush takes effect only after its delay.
- A handshake bit is echoed back after its delay, so software can tell when earlier operations have completed.
- Leaving standby also completes only after its delay.

Top module: `pcm_fifo_dma`

## Requirements
- R1: After reset the control/status word reads 0x0000_2400 (transmit empty and transmit-room set), the level register reads 0x1030_3020, and all request, panic and interrupt outputs are low.
- R2: Samples leave each queue in the order they entered. A read of the data register (word address 1) returns the oldest receive sample on `bus_rdata` the cycle after the read strobe. `tx_word` shows the oldest transmit sample the cycle after `tx_pop`.
- R3: A data write to a full transmit queue drops the word and sets the transmit error (control bit 15). A push to a full receive queue drops the word and sets the receive error (control bit 16). Either error clears when 1 is written to its bit in the control word, or to the matching bit in the interrupt status word (bit 2 transmit, bit 3 receive).
- R4: The level register (word address 2) holds transmit panic in 31:24, receive panic in 23:16, transmit request in 15:8 and receive request in 7:0. `tx_dreq` is high while transmit fill is at or below the transmit request level, and `tx_panic` while it is at or below the transmit panic level. Both outputs need module enable (bit 0) and DMA enable (bit 9), and follow the fill one cycle later.
- R5: `rx_dreq` is high while receive fill is above the receive request level, and `rx_panic` while it is above the receive panic level. They use the same enable conditions and the same timing as in R4.
- R6: Writing 1 to control bit 3 (transmit) or bit 4 (receive) empties that queue on the second `bclk_tick` after the write. Until then the bit reads 1 and the contents are intact. A flush that lands in the same cycle as a data write wins, and the word is dropped.
- R7: Control bit 24 reads back the value last written to it only after two `bclk_tick` strobes have followed that control write.
- R8: Writing control bit 25 as 1 releases standby. The bit reads 1 after four `bclk_tick` strobes, and writing it as 0 returns to standby at once. Serializer pops and pushes are ignored unless the block is awake and the module enable and the direction enable are set (bit 2 transmit, bit 1 receive).
- R9: The interrupt status word (address 4) reads {rx_err, tx_err, rx_need, tx_room} in bits 3:0. `irq` is high one cycle after any bit that is set there is also set in the interrupt enable word (address 3).
- R10: The control word reports status flags in these bits:
  - bit 10: transmit empty
  - bit 11: receive data present
  - bit 12: receive full
  - bit 13: transmit room, meaning transmit fill is below half the depth
  - bit 14: receive need, meaning receive fill is at least half the depth

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| bclk_tick | input | 1 | One-cycle strobe per PCM bit-clock period |
| tx_pop | input | 1 | Serializer takes one transmit sample |
| tx_word | output | 32 | Transmit sample most recently popped |
| rx_push | input | 1 | Serializer delivers one receive sample |
| rx_word | input | 32 | Receive sample to enqueue |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit DMA panic |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive DMA panic |
| irq | output | 1 | Interrupt request |

## Verification
A pending flush can complete in the same cycle as a bus write into the queue it empties. The bench provokes this by starting a transmit flush and letting one tick pass. It then drives the second tick and a data write in one cycle, and expects the queue to read empty afterwards with no error flag. Long sweeps of the fill level from empty to full are checked against request and panic levels computed arithmetically, first with the reset levels and then with a small reprogrammed set.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_DATA   = 3'd1;
  localparam logic [2:0] A_LEVELS = 3'd2;
  localparam logic [2:0] A_INTEN  = 3'd3;
  localparam logic [2:0] A_INTST  = 3'd4;

  localparam int B_EN      = 0;
  localparam int B_RXRUN   = 1;
  localparam int B_TXRUN   = 2;
  localparam int B_TXCLR   = 3;
  localparam int B_RXCLR   = 4;
  localparam int B_DMA     = 9;
  localparam int B_TXEMPTY = 10;
  localparam int B_RXDATA  = 11;
  localparam int B_RXFULL  = 12;
  localparam int B_TXROOM  = 13;
  localparam int B_RXNEED  = 14;
  localparam int B_TXERR   = 15;
  localparam int B_RXERR   = 16;
  localparam int B_SYNC    = 24;
  localparam int B_WAKE    = 25;

  localparam int I_TXROOM = 0;
  localparam int I_RXNEED = 1;
  localparam int I_TXERR  = 2;
  localparam int I_RXERR  = 3;

  typedef struct packed {
    logic [7:0] tx_panic;
    logic [7:0] rx_panic;
    logic [7:0] tx_req;
    logic [7:0] rx_req;
  } levels_t;
endpackage

// File: rtl/pcm_tick_delay.sv
module pcm_tick_delay #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(TICKS);
    end else if (busy && tick) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end

  assign done = busy && tick && (cnt == CW'(1)) && !start && !abort;
endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] q,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/pcm_level_cmp.sv
module pcm_level_cmp #(
  parameter bit IS_TX = 1'b1,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic [LW-1:0] level,
  input  logic [7:0]    req_lvl,
  input  logic [7:0]    panic_lvl,
  output logic          dreq,
  output logic          panic
);
  localparam int CMP_W = (LW > 8) ? LW + 1 : 9;
  logic [CMP_W-1:0] lv, rq, pn;
  logic dreq_c, panic_c;

  assign lv = CMP_W'(level);
  assign rq = CMP_W'(req_lvl);
  assign pn = CMP_W'(panic_lvl);

  generate
    if (IS_TX) begin : g_drain
      assign dreq_c  = (lv <= rq);
      assign panic_c = (lv <= pn);
    end else begin : g_fill
      assign dreq_c  = (lv > rq);
      assign panic_c = (lv > pn);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq  <= 1'b0;
      panic <= 1'b0;
    end else begin
      dreq  <= gate && dreq_c;
      panic <= gate && panic_c;
    end
  end
endmodule

// File: rtl/pcm_fifo_dma.sv
module pcm_fifo_dma
  import pcm_fifo_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          DEPTH      = 64,
  parameter int          CLR_TICKS  = 2,
  parameter int          SYNC_TICKS = 2,
  parameter int          WAKE_TICKS = 4,
  parameter logic [31:0] LEVELS_RST = 32'h1030_3020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              bclk_tick,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_word,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_word,
  output logic              tx_dreq,
  output logic              tx_panic,
  output logic              rx_dreq,
  output logic              rx_panic,
  output logic              irq
);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic en, rx_run, tx_run, dma_en;
  logic tx_err, rx_err, sync_wr, sync_rd, awake;
  logic [3:0] int_en;
  levels_t lv;

  logic wr_ctrl, wr_data, wr_lvls, wr_inten, wr_intst, rd_data;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_data  = bus_wr && bus_addr == A_DATA;
  assign wr_lvls  = bus_wr && bus_addr == A_LEVELS;
  assign wr_inten = bus_wr && bus_addr == A_INTEN;
  assign wr_intst = bus_wr && bus_addr == A_INTST;
  assign rd_data  = bus_rd && bus_addr == A_DATA;

  // timed operations
  logic tx_clr_busy, tx_clr_done, rx_clr_busy, rx_clr_done;
  logic sync_busy, sync_done, wake_busy, wake_done, wake_start, wake_abort;

  pcm_tick_delay #(.TICKS(CLR_TICKS)) u_txclr (
    .clk(clk), .rst(rst), .start(wr_ctrl && bus_wdata[B_TXCLR]), .abort(1'b0),
    .tick(bclk_tick), .busy(tx_clr_busy), .done(tx_clr_done));
  pcm_tick_delay #(.TICKS(CLR_TICKS)) u_rxclr (
    .clk(clk), .rst(rst), .start(wr_ctrl && bus_wdata[B_RXCLR]), .abort(1'b0),
    .tick(bclk_tick), .busy(rx_clr_busy), .done(rx_clr_done));
  pcm_tick_delay #(.TICKS(SYNC_TICKS)) u_sync (
    .clk(clk), .rst(rst), .start(wr_ctrl), .abort(1'b0),
    .tick(bclk_tick), .busy(sync_busy), .done(sync_done));

  assign wake_start = wr_ctrl && bus_wdata[B_WAKE] && !awake && !wake_busy;
  assign wake_abort = wr_ctrl && !bus_wdata[B_WAKE];

  pcm_tick_delay #(.TICKS(WAKE_TICKS)) u_wake (
    .clk(clk), .rst(rst), .start(wake_start), .abort(wake_abort),
    .tick(bclk_tick), .busy(wake_busy), .done(wake_done));

  // sample queues
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_take, rx_take;
  logic [DATA_W-1:0] rx_q;

  assign tx_take = tx_pop  && en && tx_run && awake;
  assign rx_take = rx_push && en && rx_run && awake;

  pcm_sample_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr_done), .push(wr_data),
    .din(DATA_W'(bus_wdata)), .pop(tx_take), .q(tx_word),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  pcm_sample_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr_done), .push(rx_take),
    .din(rx_word), .pop(rd_data), .q(rx_q),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  // control and sticky state
  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; rx_run <= 1'b0; tx_run <= 1'b0; dma_en <= 1'b0;
      lv <= LEVELS_RST;
      int_en <= '0;
      tx_err <= 1'b0; rx_err <= 1'b0;
      sync_wr <= 1'b0; sync_rd <= 1'b0;
      awake <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en      <= bus_wdata[B_EN];
        rx_run  <= bus_wdata[B_RXRUN];
        tx_run  <= bus_wdata[B_TXRUN];
        dma_en  <= bus_wdata[B_DMA];
        sync_wr <= bus_wdata[B_SYNC];
      end
      if (wr_lvls)  lv <= bus_wdata;
      if (wr_inten) int_en <= bus_wdata[3:0];
      if (sync_done) sync_rd <= sync_wr;
      if (wake_abort)     awake <= 1'b0;
      else if (wake_done) awake <= 1'b1;

      if (wr_data && tx_full && !tx_clr_done) tx_err <= 1'b1;
      else if ((wr_ctrl && bus_wdata[B_TXERR]) || (wr_intst && bus_wdata[I_TXERR]))
        tx_err <= 1'b0;

      if (rx_take && rx_full && !rx_clr_done) rx_err <= 1'b1;
      else if ((wr_ctrl && bus_wdata[B_RXERR]) || (wr_intst && bus_wdata[I_RXERR]))
        rx_err <= 1'b0;
    end
  end

  // status views
  logic tx_room, rx_need;
  logic [3:0] int_src;
  logic [31:0] ctrl_view;

  assign tx_room = (tx_lvl < LW'(HALF));
  assign rx_need = (rx_lvl >= LW'(HALF));
  assign int_src = {rx_err, tx_err, rx_need, tx_room};

  always_comb begin
    ctrl_view = '0;
    ctrl_view[B_EN]      = en;
    ctrl_view[B_RXRUN]   = rx_run;
    ctrl_view[B_TXRUN]   = tx_run;
    ctrl_view[B_TXCLR]   = tx_clr_busy;
    ctrl_view[B_RXCLR]   = rx_clr_busy;
    ctrl_view[B_DMA]     = dma_en;
    ctrl_view[B_TXEMPTY] = tx_empty;
    ctrl_view[B_RXDATA]  = !rx_empty;
    ctrl_view[B_RXFULL]  = rx_full;
    ctrl_view[B_TXROOM]  = tx_room;
    ctrl_view[B_RXNEED]  = rx_need;
    ctrl_view[B_TXERR]   = tx_err;
    ctrl_view[B_RXERR]   = rx_err;
    ctrl_view[B_SYNC]    = sync_rd;
    ctrl_view[B_WAKE]    = awake;
  end

  // read path and interrupt
  logic [31:0] rd_q;
  logic rd_fifo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= '0;
      rd_fifo_q <= 1'b0;
      irq       <= 1'b0;
    end else begin
      rd_fifo_q <= rd_data;
      irq       <= |(int_en & int_src);
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:   rd_q <= ctrl_view;
          A_LEVELS: rd_q <= lv;
          A_INTEN:  rd_q <= {28'd0, int_en};
          A_INTST:  rd_q <= {28'd0, int_src};
          default:  rd_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rd_fifo_q ? 32'(rx_q) : rd_q;

  // DMA request generation
  pcm_level_cmp #(.IS_TX(1'b1), .LW(LW)) u_txcmp (
    .clk(clk), .rst(rst), .gate(en && dma_en), .level(tx_lvl),
    .req_lvl(lv.tx_req), .panic_lvl(lv.tx_panic), .dreq(tx_dreq), .panic(tx_panic));
  pcm_level_cmp #(.IS_TX(1'b0), .LW(LW)) u_rxcmp (
    .clk(clk), .rst(rst), .gate(en && dma_en), .level(rx_lvl),
    .req_lvl(lv.rx_req), .panic_lvl(lv.rx_panic), .dreq(rx_dreq), .panic(rx_panic));
endmodule

// File: rtl/pcm_fifo_dma_chk.sv
module pcm_fifo_dma_chk #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_err,
  input logic          wr_data,
  input logic          tx_full,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          tx_clr_done,
  input logic          rx_clr_done,
  input logic          sync_done,
  input logic          sync_rd,
  input logic          awake,
  input logic          wake_done,
  input logic          tx_dreq,
  input logic          en,
  input logic          dma_en,
  input logic          irq,
  input logic [3:0]    int_en,
  input logic [3:0]    int_src
);
  a_r3_tx_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_err) |-> $past(wr_data && tx_full));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  a_r6_tx_flush: assert property (@(posedge clk) disable iff (rst)
    tx_clr_done |=> (tx_lvl == '0));

  a_r6_rx_flush: assert property (@(posedge clk) disable iff (rst)
    rx_clr_done |=> (rx_lvl == '0));

  a_r7_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_done |=> $stable(sync_rd));

  a_r8_wake_after_count: assert property (@(posedge clk) disable iff (rst)
    $rose(awake) |-> $past(wake_done));

  a_r4_dreq_gated: assert property (@(posedge clk) disable iff (rst)
    tx_dreq |-> $past(en && dma_en));

  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(int_en & int_src)));
endmodule

bind pcm_fifo_dma pcm_fifo_dma_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tx_err(tx_err), .wr_data(wr_data), .tx_full(tx_full),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_clr_done(tx_clr_done),
  .rx_clr_done(rx_clr_done), .sync_done(sync_done), .sync_rd(sync_rd),
  .awake(awake), .wake_done(wake_done), .tx_dreq(tx_dreq), .en(en),
  .dma_en(dma_en), .irq(irq), .int_en(int_en), .int_src(int_src));

// File: tb/sim_pcm_fifo_dma.sv
module sim_pcm_fifo_dma;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam logic [31:0] ON = 32'h0200_0207; // wake, dma, tx/rx run, enable

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bclk_tick = 0, tx_pop = 0, rx_push = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, tx_word, rx_word = 0;
  logic tx_dreq, tx_panic, rx_dreq, rx_panic, irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_fifo_dma u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bclk_tick(bclk_tick),
    .tx_pop(tx_pop), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
    .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq),
    .rx_panic(rx_panic), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); bclk_tick = 1;
    @(negedge clk); bclk_tick = 0;
  endtask

  task automatic pop();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); rx_push = 1; rx_word = w;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    br(3'd0, r); chk("R1 ctrl", r, 32'h0000_2400);
    br(3'd2, r); chk("R1 levels", r, 32'h1030_3020);
    chk("R1 outs", {27'd0, tx_dreq, tx_panic, rx_dreq, rx_panic, irq}, 0);

    // R8 standby release
    bw(3'd0, ON);
    repeat (3) tick();
    br(3'd0, r); chk("R8 asleep after 3", 32'(r[25]), 0);
    push(32'hDEAD);
    br(3'd0, r); chk("R8 push ignored asleep", 32'(r[11]), 0);
    tick();
    br(3'd0, r); chk("R8 awake after 4", 32'(r[25]), 1);

    // R4 transmit sweep, reset levels
    for (int n = 0; n <= DEPTH; n++) begin
      settle();
      chk("R4 tx_dreq", 32'(tx_dreq), 32'(n <= 'h30));
      chk("R4 tx_panic", 32'(tx_panic), 32'(n <= 'h10));
      if (n == DEPTH/2 - 1) begin br(3'd0, r); chk("R10 room", 32'(r[13]), 1); end
      if (n == DEPTH/2)     begin br(3'd0, r); chk("R10 no room", 32'(r[13]), 0); end
      if (n < DEPTH) bw(3'd1, 32'hA000 + n);
    end
    br(3'd0, r); chk("R10 full tx flags", r & 32'h0000_A400, 0);
    bw(3'd1, 32'hBAD);
    br(3'd0, r); chk("R3 tx overflow err", 32'(r[15]), 1);
    bw(3'd0, ON | (32'h1 << 15));
    br(3'd0, r); chk("R3 tx err w1c", 32'(r[15]), 0);
    for (int k = 0; k < DEPTH; k++) begin
      pop(); chk("R2 tx order", tx_word, 32'hA000 + k);
    end
    br(3'd0, r); chk("R3 dropped word absent", 32'(r[10]), 1);

    // R5 receive sweep
    for (int n = 0; n <= DEPTH; n++) begin
      settle();
      chk("R5 rx_dreq", 32'(rx_dreq), 32'(n > 'h20));
      chk("R5 rx_panic", 32'(rx_panic), 32'(n > 'h30));
      if (n == DEPTH/2 - 1) begin br(3'd0, r); chk("R10 no need", 32'(r[14]), 0); end
      if (n == DEPTH/2)     begin br(3'd0, r); chk("R10 need", 32'(r[14]), 1); end
      if (n < DEPTH) push(32'hB000 + n);
    end
    br(3'd0, r); chk("R10 rx full", 32'(r[12]), 1);
    push(32'hBAD);
    br(3'd4, r); chk("R3 rx overflow err", 32'(r[3]), 1);
    bw(3'd4, 32'h8);
    br(3'd0, r); chk("R3 rx err w1c", 32'(r[16]), 0);
    for (int k = 0; k < DEPTH; k++) begin
      br(3'd1, r); chk("R2 rx order", r, 32'hB000 + k);
    end
    br(3'd0, r); chk("R10 rx empty", 32'(r[11]), 0);

    // R4/R5 reprogrammed levels
    bw(3'd2, 32'h050A_0307);
    for (int n = 0; n <= 8; n++) begin
      settle();
      chk("R4 tx_dreq small", 32'(tx_dreq), 32'(n <= 3));
      chk("R4 tx_panic small", 32'(tx_panic), 32'(n <= 5));
      if (n < 8) bw(3'd1, 32'h100 + n);
    end
    for (int n = 0; n <= 12; n++) begin
      settle();
      chk("R5 rx_dreq small", 32'(rx_dreq), 32'(n > 7));
      chk("R5 rx_panic small", 32'(rx_panic), 32'(n > 10));
      if (n < 12) push(32'h200 + n);
    end

    // R6 flush after two ticks
    bw(3'd0, ON | 32'h18);
    tick();
    br(3'd0, r); chk("R6 pending", r & 32'h0000_0C18, 32'h0000_0818);
    tick();
    br(3'd0, r); chk("R6 flushed", r & 32'h0000_0C18, 32'h0000_0400);

    // R6 flush and data write in the same cycle
    bw(3'd1, 32'h1); bw(3'd1, 32'h2);
    bw(3'd0, ON | 32'h8);
    tick();
    @(negedge clk); bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h3; bclk_tick = 1;
    @(negedge clk); bus_wr = 0; bclk_tick = 0;
    br(3'd0, r); chk("R6 flush beats write", r & 32'h0000_8400, 32'h0000_0400);

    // R4 DMA enable gating
    bw(3'd0, ON & ~(32'h1 << 9));
    settle(); chk("R4 dreq gated", 32'(tx_dreq), 0);
    bw(3'd0, ON);
    settle(); chk("R4 dreq ungated", 32'(tx_dreq), 1);

    // R8 direction enable gating
    bw(3'd1, 32'h77);
    bw(3'd0, ON & ~32'h4);
    pop();
    br(3'd0, r); chk("R8 pop ignored", 32'(r[10]), 0);
    bw(3'd0, ON);
    pop(); chk("R2 pop word", tx_word, 32'h77);
    br(3'd0, r); chk("R8 pop taken", 32'(r[10]), 1);

    // R7 sync echo
    bw(3'd0, ON | (32'h1 << 24));
    br(3'd0, r); chk("R7 sync 0 ticks", 32'(r[24]), 0);
    tick();
    br(3'd0, r); chk("R7 sync 1 tick", 32'(r[24]), 0);
    tick();
    br(3'd0, r); chk("R7 sync 2 ticks", 32'(r[24]), 1);
    bw(3'd0, ON);
    tick(); tick();
    br(3'd0, r); chk("R7 sync back 0", 32'(r[24]), 0);

    // R9 interrupts
    bw(3'd3, 32'h1);
    settle(); chk("R9 irq room", 32'(irq), 1);
    br(3'd4, r); chk("R9 status", r, 32'h1);
    bw(3'd3, 32'h2);
    settle(); chk("R9 irq masked", 32'(irq), 0);
    bw(3'd3, 32'h4);
    for (int k = 0; k <= DEPTH; k++) bw(3'd1, 32'(k));
    settle(); chk("R9 irq tx err", 32'(irq), 1);
    br(3'd4, r); chk("R9 status err", r, 32'h4);
    bw(3'd4, 32'h4);
    settle(); chk("R9 irq cleared", 32'(irq), 0);

    // R8 return to standby
    bw(3'd0, ON & ~(32'h1 << 25));
    br(3'd0, r); chk("R8 standby", 32'(r[25]), 0);

    summary();
  end
endmodule